// File: doc/BRIEF.md
# PHY Discovery and Link-Wait Sequencer

This block finds the Ethernet PHY attached to a management bus and then waits until that PHY reports a usable link. It does not serialize frames on the bus itself. Instead it hands register-read requests (PHY address, register number, one-cycle request strobe) to a separate management-bus engine, which answers with a one-cycle done strobe and the 16-bit read data.

After a start pulse the sequencer walks the PHY addresses from low to high and reads the first identifier register at each one. The value 0xFFFF marks an empty address. The first address that returns any other value is taken. The second identifier register at that address is then read to complete a 32-bit identifier, which is compared against one configured known value. If no address answers, the whole walk is repeated a fixed number of times, with a long pause before every pass after the first. This gives a PHY that is slow to leave reset time to wake up. Once a PHY is known, the sequencer polls its status register at a fixed spacing until autonegotiation and link are both reported. If the poll budget runs out first, it raises a timeout flag instead.

The found address and identifier are kept. A later start skips the search and goes straight to status polling.

Top module: `phy_probe_seq`

## Requirements
- R1: Each search pass reads register 2 at addresses 0, 1, 2, … upward in strictly ascending order, ending at address 31 at the latest.
- R2: A register-2 value of 0xFFFF means the address is empty. The first address whose value differs is taken as the PHY address, and no further register-2 read follows in that search.
- R3: After a hit, register 3 is read at the same address. The identifier output is {register-2 value, register-3 value}, with register 2 in bits 31:16.
- R4: A search makes at most SCAN_PASSES passes. Between the end of one pass and the first read of the next there are at least RETRY_TICKS clock cycles. No pause comes before the first pass.
- R5: If every pass misses, the not-found flag is set, the found flag stays low, the reported address stays 0 and no status poll is issued.
- R6: When a PHY has already been found, a new start issues no register-2 or register-3 read and keeps the cached address and identifier.
- R7: After discovery, register 1 is read repeatedly. Link-up is set only when one single read has bit 5 (autonegotiation complete) and bit 2 (link status) both at 1. A value with only one of the two bits set leads to another poll.
- R8: Consecutive status polls are at least POLL_TICKS cycles apart, and at most POLL_LIMIT polls are made. If the limit is reached without success, the timeout flag is set and link-up stays low. The two flags are never high together.
- R9: The known-ID flag is 1 exactly when the found 32-bit identifier equals the KNOWN_ID parameter, and 0 for any other identifier.
- R10: Busy is high from the cycle after a start until the results are final. Each request strobe lasts one cycle and occurs only while busy. A start clears the link-up and timeout flags of the previous run.
- R11: After reset, busy, the request strobe, found, not-found, known-ID, link-up and timeout are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to run discovery and link wait |
| busy | output | 1 | Sequence in progress |
| rd_req | output | 1 | One-cycle read request to the management-bus engine |
| rd_phy | output | 5 | PHY address of the request |
| rd_reg | output | 5 | Register number of the request |
| rd_done | input | 1 | One-cycle read completion from the engine |
| rd_data | input | 16 | Read data, valid with rd_done |
| phy_found | output | 1 | A PHY has been identified |
| phy_absent | output | 1 | The last search found no PHY |
| phy_addr | output | 5 | Address of the found PHY |
| phy_id | output | 32 | 32-bit identifier of the found PHY |
| id_known | output | 1 | Identifier equals KNOWN_ID |
| link_up | output | 1 | Autonegotiation complete and link up in one status read |
| link_timeout | output | 1 | Poll budget used up without link |

## Verification
The bench builds the block with SCAN_PASSES=3, RETRY_TICKS=40, POLL_TICKS=12 and POLL_LIMIT=5. With these values the full search over an empty bus (96 reads), a PHY that wakes only on the last pass, and an exhausted poll budget all finish in a few hundred cycles. Measured pass and poll spacing can then be compared against the small tick counts. A responder model with a three-cycle latency places the PHY at addresses 0, 3, 5 and 31. It feeds status values with only one of the two required bits before the full pair.

// File: rtl/phy_probe_pkg.sv
// Shared state encoding and register constants for the PHY probe sequencer.
// Assumes the management bus uses 5-bit PHY and register numbers.
package phy_probe_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SCAN_REQ,
        ST_SCAN_WAIT,
        ST_ID2_REQ,
        ST_ID2_WAIT,
        ST_PASS_GAP,
        ST_POLL_REQ,
        ST_POLL_WAIT,
        ST_POLL_GAP
    } probe_state_e;

    localparam logic [4:0]  REG_STATUS = 5'd1;
    localparam logic [4:0]  REG_ID_HI  = 5'd2;
    localparam logic [4:0]  REG_ID_LO  = 5'd3;
    localparam int          BIT_ANEG   = 5;
    localparam int          BIT_LINK   = 2;
    localparam logic [15:0] EMPTY_WORD = 16'hFFFF;

endpackage

// File: rtl/probe_timer.sv
// Down-counting delay timer. A load sets the count; expired is high while the count is zero.
// Assumes load values of TICKS-1 give a wait of TICKS cycles in the caller's gap state.
module probe_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    // Load or count down toward zero, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/probe_counter.sv
// Clearable up-counter used for address, pass and poll indices.
// Assumes the caller never increments past the range it compares against.
module probe_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    // Clear has priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (clr)
            q <= '0;
        else if (inc)
            q <= q + 1'b1;
    end
endmodule

// File: rtl/phy_probe_seq.sv
// PHY discovery and link-wait sequencer.
// Scans PHY addresses for a responding identifier register, assembles the
// 32-bit identifier, retries whole passes with a pause, then polls the status
// register until autonegotiation and link are both reported.
// Assumes the read engine answers each request with one rd_done pulse at
// least one cycle after rd_req, and holds no second request outstanding.
module phy_probe_seq #(
    parameter int          ADDR_COUNT  = 32,
    parameter int          SCAN_PASSES = 11,
    parameter int          RETRY_TICKS = 1000000,
    parameter int          POLL_TICKS  = 50000,
    parameter int          POLL_LIMIT  = 1000,
    parameter logic [31:0] KNOWN_ID    = 32'h0022561B
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        busy,
    output logic        rd_req,
    output logic [4:0]  rd_phy,
    output logic [4:0]  rd_reg,
    input  logic        rd_done,
    input  logic [15:0] rd_data,
    output logic        phy_found,
    output logic        phy_absent,
    output logic [4:0]  phy_addr,
    output logic [31:0] phy_id,
    output logic        id_known,
    output logic        link_up,
    output logic        link_timeout
);
    import phy_probe_pkg::*;

    localparam int ADDR_W = 5;
    localparam int PASS_W = $clog2(SCAN_PASSES + 1);
    localparam int POLL_W = $clog2(POLL_LIMIT + 1);
    localparam int T_MAX  = (RETRY_TICKS > POLL_TICKS) ? RETRY_TICKS : POLL_TICKS;
    localparam int TMR_W  = $clog2(T_MAX + 1);

    probe_state_e state_q, state_d;

    logic              addr_clr, addr_inc, pass_clr, pass_inc, poll_clr, poll_inc;
    logic              tmr_load, tmr_expired;
    logic [TMR_W-1:0]  tmr_val;
    logic [ADDR_W-1:0] addr_q;
    logic [PASS_W-1:0] pass_q;
    logic [POLL_W-1:0] poll_q;

    logic hit, link_ok, last_addr, last_pass, last_poll;

    assign hit       = rd_data != EMPTY_WORD;
    assign link_ok   = rd_data[BIT_ANEG] && rd_data[BIT_LINK];
    assign last_addr = addr_q == ADDR_W'(ADDR_COUNT - 1);
    assign last_pass = pass_q == PASS_W'(SCAN_PASSES - 1);
    assign last_poll = poll_q == POLL_W'(POLL_LIMIT - 1);

    probe_counter #(.W(ADDR_W)) u_addr_cnt (
        .clk(clk), .rst_n(rst_n), .clr(addr_clr), .inc(addr_inc), .q(addr_q));
    probe_counter #(.W(PASS_W)) u_pass_cnt (
        .clk(clk), .rst_n(rst_n), .clr(pass_clr), .inc(pass_inc), .q(pass_q));
    probe_counter #(.W(POLL_W)) u_poll_cnt (
        .clk(clk), .rst_n(rst_n), .clr(poll_clr), .inc(poll_inc), .q(poll_q));
    probe_timer #(.W(TMR_W)) u_gap_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .expired(tmr_expired));

    // Next-state logic and counter/timer control.
    always_comb begin
        state_d  = state_q;
        addr_clr = 1'b0; addr_inc = 1'b0;
        pass_clr = 1'b0; pass_inc = 1'b0;
        poll_clr = 1'b0; poll_inc = 1'b0;
        tmr_load = 1'b0; tmr_val  = '0;
        case (state_q)
            ST_IDLE: if (start) begin
                poll_clr = 1'b1;
                if (phy_found) begin
                    state_d = ST_POLL_REQ;
                end else begin
                    addr_clr = 1'b1;
                    pass_clr = 1'b1;
                    state_d  = ST_SCAN_REQ;
                end
            end
            ST_SCAN_REQ: state_d = ST_SCAN_WAIT;
            ST_SCAN_WAIT: if (rd_done) begin
                if (hit) begin
                    state_d = ST_ID2_REQ;
                end else if (!last_addr) begin
                    addr_inc = 1'b1;
                    state_d  = ST_SCAN_REQ;
                end else if (last_pass) begin
                    state_d = ST_IDLE;
                end else begin
                    addr_clr = 1'b1;
                    pass_inc = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(RETRY_TICKS - 1);
                    state_d  = ST_PASS_GAP;
                end
            end
            ST_PASS_GAP: if (tmr_expired) state_d = ST_SCAN_REQ;
            ST_ID2_REQ:  state_d = ST_ID2_WAIT;
            ST_ID2_WAIT: if (rd_done) state_d = ST_POLL_REQ;
            ST_POLL_REQ: state_d = ST_POLL_WAIT;
            ST_POLL_WAIT: if (rd_done) begin
                if (link_ok || last_poll) begin
                    state_d = ST_IDLE;
                end else begin
                    poll_inc = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(POLL_TICKS - 1);
                    state_d  = ST_POLL_GAP;
                end
            end
            ST_POLL_GAP: if (tmr_expired) state_d = ST_POLL_REQ;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result registers: cached identity and per-run flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_found    <= 1'b0;
            phy_absent   <= 1'b0;
            phy_addr     <= '0;
            phy_id       <= '0;
            id_known     <= 1'b0;
            link_up      <= 1'b0;
            link_timeout <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    link_up      <= 1'b0;
                    link_timeout <= 1'b0;
                    phy_absent   <= 1'b0;
                end
                ST_SCAN_WAIT: if (rd_done) begin
                    if (hit) begin
                        phy_addr      <= addr_q;
                        phy_id[31:16] <= rd_data;
                    end else if (last_addr && last_pass) begin
                        phy_absent <= 1'b1;
                    end
                end
                ST_ID2_WAIT: if (rd_done) begin
                    phy_id[15:0] <= rd_data;
                    phy_found    <= 1'b1;
                    id_known     <= {phy_id[31:16], rd_data} == KNOWN_ID;
                end
                ST_POLL_WAIT: if (rd_done) begin
                    if (link_ok)        link_up      <= 1'b1;
                    else if (last_poll) link_timeout <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Request outputs decoded from the state.
    always_comb begin
        rd_req = 1'b0;
        rd_reg = '0;
        rd_phy = phy_addr;
        case (state_q)
            ST_SCAN_REQ: begin rd_req = 1'b1; rd_reg = REG_ID_HI; rd_phy = addr_q; end
            ST_ID2_REQ:  begin rd_req = 1'b1; rd_reg = REG_ID_LO;  end
            ST_POLL_REQ: begin rd_req = 1'b1; rd_reg = REG_STATUS; end
            default: ;
        endcase
    end

    assign busy = state_q != ST_IDLE;
endmodule

// File: rtl/phy_probe_checks.sv
// Protocol and ordering checks for phy_probe_seq, attached by bind.
// Assumes register 2 is the scan register, 3 the second identifier, 1 the status.
module phy_probe_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        rd_req,
    input logic [4:0]  rd_phy,
    input logic [4:0]  rd_reg,
    input logic        rd_done,
    input logic [15:0] rd_data,
    input logic        phy_found,
    input logic        phy_absent,
    input logic        link_up,
    input logic        link_timeout
);
    logic [4:0] last_scan;

    // Remember the address of the most recent scan read.
    always_ff @(posedge clk) begin
        if (!rst_n)                      last_scan <= '0;
        else if (rd_req && rd_reg == 5'd2) last_scan <= rd_phy;
    end

    assert_scan_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_reg == 5'd2 && rd_phy != 5'd0 |-> rd_phy == 5'(last_scan + 5'd1));

    assert_id2_same_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_reg == 5'd3 |-> rd_phy == last_scan);

    assert_found_absent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(phy_found && phy_absent));

    assert_poll_needs_phy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && rd_reg == 5'd1 |-> phy_found);

    assert_link_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> $past(rd_done && rd_data[5] && rd_data[2]));

    assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_up && link_timeout));

    assert_req_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    assert_req_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy);
endmodule

bind phy_probe_seq phy_probe_checks u_checks (
    .clk(clk), .rst_n(rst_n), .busy(busy), .rd_req(rd_req), .rd_phy(rd_phy),
    .rd_reg(rd_reg), .rd_done(rd_done), .rd_data(rd_data), .phy_found(phy_found),
    .phy_absent(phy_absent), .link_up(link_up), .link_timeout(link_timeout)
);

// File: tb/phy_probe_seq_bench.sv
// Directed bench: a read-engine model with fixed latency answers scan,
// identifier and status reads; one task per scenario checks its own results.
module phy_probe_seq_bench;
    localparam int PASSES = 3;
    localparam int RETRY  = 40;
    localparam int PGAP   = 12;
    localparam int PLIM   = 5;
    localparam logic [31:0] KID = 32'h0022561B;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, rd_req, rd_done = 1'b0;
    logic [4:0] rd_phy, rd_reg, phy_addr;
    logic [15:0] rd_data = '0;
    logic phy_found, phy_absent, id_known, link_up, link_timeout;
    logic [31:0] phy_id;

    int checks = 0, errors = 0, cyc = 0;

    // Model configuration and statistics.
    int phy_at = -1, wake_pass = 0, link_after = -1;
    logic [15:0] id_hi = '0, id_lo = '0;
    int scan_reads, id2_reads, polls, passes_seen, id2_addr;
    int exp_next, order_bad, min_pass_gap, min_poll_gap, last_scan_cyc, last_poll_cyc;
    int pend = 0;
    logic [4:0] m_phy, m_reg;

    always #2.5 clk = ~clk;

    phy_probe_seq #(
        .ADDR_COUNT(32), .SCAN_PASSES(PASSES), .RETRY_TICKS(RETRY),
        .POLL_TICKS(PGAP), .POLL_LIMIT(PLIM), .KNOWN_ID(KID)
    ) u_phy_probe_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .rd_req(rd_req),
        .rd_phy(rd_phy), .rd_reg(rd_reg), .rd_done(rd_done), .rd_data(rd_data),
        .phy_found(phy_found), .phy_absent(phy_absent), .phy_addr(phy_addr),
        .phy_id(phy_id), .id_known(id_known), .link_up(link_up),
        .link_timeout(link_timeout)
    );

    function automatic logic [15:0] respond(input logic [4:0] a, input logic [4:0] r);
        int n;
        if (r == 5'd2) return (int'(a) == phy_at && passes_seen - 1 >= wake_pass) ? id_hi : 16'hFFFF;
        if (r == 5'd3) return id_lo;
        n = polls - 1;
        if (link_after < 0 || n < link_after) return (n % 2 == 0) ? 16'h0020 : 16'h0004;
        return 16'h002D;
    endfunction

    // Read-engine model and request statistics.
    always @(posedge clk) begin
        cyc = cyc + 1;
        rd_done <= 1'b0;
        if (!rst_n) begin
            pend <= 0;
        end else if (rd_req) begin
            pend  <= LAT;
            m_phy <= rd_phy;
            m_reg <= rd_reg;
            if (rd_reg == 5'd2) begin
                if (int'(rd_phy) != exp_next) order_bad = 1;
                exp_next = (rd_phy == 5'd31) ? 0 : int'(rd_phy) + 1;
                if (rd_phy == 5'd0) begin
                    if (scan_reads > 0 && cyc - last_scan_cyc < min_pass_gap)
                        min_pass_gap = cyc - last_scan_cyc;
                    passes_seen = passes_seen + 1;
                end
                last_scan_cyc = cyc;
                scan_reads = scan_reads + 1;
            end else if (rd_reg == 5'd3) begin
                id2_reads = id2_reads + 1;
                id2_addr  = int'(rd_phy);
            end else if (rd_reg == 5'd1) begin
                if (polls > 0 && cyc - last_poll_cyc < min_poll_gap)
                    min_poll_gap = cyc - last_poll_cyc;
                last_poll_cyc = cyc;
                polls = polls + 1;
            end
        end else if (pend > 1) begin
            pend <= pend - 1;
        end else if (pend == 1) begin
            pend    <= 0;
            rd_done <= 1'b1;
            rd_data <= respond(m_phy, m_reg);
        end
    end

    // Global watchdog.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_stats();
        scan_reads = 0; id2_reads = 0; polls = 0; passes_seen = 0; id2_addr = -1;
        exp_next = 0; order_bad = 0; min_pass_gap = 1000000; min_poll_gap = 1000000;
        last_scan_cyc = 0; last_poll_cyc = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        clear_stats();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_start();
        int waited;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 busy after start", 32'(busy), 32'd1);
        waited = 0;
        while (busy && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        chk("R10 run completes", 32'(busy), 32'd0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R11 busy", 32'(busy), 0);
        chk("R11 rd_req", 32'(rd_req), 0);
        chk("R11 found", 32'(phy_found), 0);
        chk("R11 absent", 32'(phy_absent), 0);
        chk("R11 known", 32'(id_known), 0);
        chk("R11 link", 32'(link_up), 0);
        chk("R11 timeout", 32'(link_timeout), 0);
    endtask

    task automatic t_basic();
        do_reset();
        phy_at = 5; wake_pass = 0; id_hi = 16'h0022; id_lo = 16'h561B; link_after = 2;
        run_start();
        chk("R1 order", order_bad, 0);
        chk("R2 scan stops at hit", scan_reads, 6);
        chk("R2 addr", 32'(phy_addr), 5);
        chk("R3 id2 same addr", id2_addr, 5);
        chk("R3 id", phy_id, 32'h0022561B);
        chk("R9 known", 32'(id_known), 1);
        chk("R7 partial bits repoll", polls, 3);
        chk("R7 link", 32'(link_up), 1);
        chk("R8 no timeout", 32'(link_timeout), 0);
        chk("R8 poll spacing", 32'(min_poll_gap >= PGAP), 1);
    endtask

    task automatic t_late_wake();
        do_reset();
        phy_at = 0; wake_pass = 2; id_hi = 16'h2000; id_lo = 16'h5C90; link_after = 0;
        run_start();
        chk("R4 reads over passes", scan_reads, 65);
        chk("R4 pass gap", 32'(min_pass_gap >= RETRY), 1);
        chk("R1 order", order_bad, 0);
        chk("R3 id", phy_id, 32'h20005C90);
        chk("R9 unknown", 32'(id_known), 0);
        chk("R7 single poll", polls, 1);
    endtask

    task automatic t_top_addr();
        do_reset();
        phy_at = 31; wake_pass = 0; id_hi = 16'h0181; id_lo = 16'h4400; link_after = 0;
        run_start();
        chk("R1 full pass", scan_reads, 32);
        chk("R2 addr 31", 32'(phy_addr), 31);
        chk("R3 id2 addr 31", id2_addr, 31);
    endtask

    task automatic t_absent();
        do_reset();
        phy_at = -1;
        run_start();
        chk("R4 all passes", scan_reads, 32 * PASSES);
        chk("R5 absent", 32'(phy_absent), 1);
        chk("R5 not found", 32'(phy_found), 0);
        chk("R5 addr 0", 32'(phy_addr), 0);
        chk("R5 no polls", polls, 0);
        chk("R5 no id2", id2_reads, 0);
    endtask

    task automatic t_timeout();
        do_reset();
        phy_at = 3; wake_pass = 0; id_hi = 16'h0022; id_lo = 16'h561B; link_after = -1;
        run_start();
        chk("R8 poll limit", polls, PLIM);
        chk("R8 timeout", 32'(link_timeout), 1);
        chk("R8 no link", 32'(link_up), 0);
    endtask

    task automatic t_cache();
        // Continues from t_timeout without reset.
        clear_stats();
        phy_at = 7; link_after = 1;
        run_start();
        chk("R6 no scan", scan_reads, 0);
        chk("R6 no id2", id2_reads, 0);
        chk("R6 cached addr", 32'(phy_addr), 3);
        chk("R6 cached id", phy_id, 32'h0022561B);
        chk("R10 timeout cleared", 32'(link_timeout), 0);
        chk("R7 link after cache", 32'(link_up), 1);
        chk("R7 polls", polls, 2);
    endtask

    initial begin
        clear_stats();
        t_reset();
        t_basic();
        t_late_wake();
        t_top_addr();
        t_absent();
        t_timeout();
        t_cache();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule